// File: doc/BRIEF.md
# Serial Programming Port Identifier Reader

This block is the host side of a serial in-system-programming link. When asked, it pulls the target's active-low programming enable, walks the target's port state machine to its idle state, issues the execute code that loads the identifier into the target's output shift register, and then clocks the identifier out one bit per strobe. The serial clock, the two control lines (a mode line and a serial data line) and the data return line are all driven or sampled by a small sequencer. No software interface is needed.

The serial clock has a high phase and a low phase. Each phase lasts a number of system clocks chosen on an input, so a slow target can be served from a fast system clock. The mode and data lines are set while the serial clock is low, one full phase before the rising edge that acts on them. The returned bits arrive least significant first and are packed into a byte. That byte is presented with a one-cycle completion pulse and a flag that says whether it equals the identifier the host expects.

Top module: `isp_id_reader`

## Requirements
- R1: While reset is low and right after it, `isp_en_n` is 1, `isp_sck` is 0, and `busy`, `done`, `id_ok` and `id_byte` are all 0.
- R2: A `start` seen in idle drives `isp_en_n` low in the next cycle, with `isp_mode`=1 and `isp_sdi`=0. The first rising edge of `isp_sck` comes exactly 2·H system cycles after `isp_en_n` falls. H is `half_len` sampled at start.
- R3: Every high phase and every low phase of `isp_sck` lasts exactly H system cycles.
- R4: A read issues exactly 10 rising edges of `isp_sck`. The first has `isp_mode`=1, `isp_sdi`=0 (return to idle). The second has `isp_mode`=0, `isp_sdi`=0 (execute). The last 8 have `isp_mode`=0, `isp_sdi`=0 (data). `isp_mode` and `isp_sdi` never change while `isp_sck` is high.
- R5: `isp_sdo` is sampled at each of the 8 data rising edges. The first sample becomes bit 0 of `id_byte` and the last becomes bit 7.
- R6: `done` is high for exactly one cycle, H cycles after the last falling edge of `isp_sck`. `id_byte` holds the new value from that cycle until the next `done`.
- R7: `id_ok` is updated with `done` and is 1 only when `id_byte` equals 8'h15.
- R8: `busy` is 1 from the cycle `isp_en_n` falls through the `done` cycle. `isp_en_n` returns to 1 in the cycle after `done`, and `isp_sck` is never high while `isp_en_n` is 1.
- R9: `start` pulses while `busy` is 1, including during the `done` cycle, have no effect on the read in progress.
- R10: A `half_len` of 0 is treated as H=1. Changes to `half_len` after start do not affect the read in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one identifier read (taken only in idle) |
| half_len | input | HALF_W (8) | System cycles per serial clock phase; 0 acts as 1 |
| isp_sdo | input | 1 | Serial data returned by the target |
| isp_en_n | output | 1 | Active-low programming enable to the target |
| isp_sck | output | 1 | Serial clock to the target |
| isp_mode | output | 1 | Mode control line to the target |
| isp_sdi | output | 1 | Serial data to the target |
| busy | output | 1 | A read is in progress |
| done | output | 1 | One-cycle completion pulse |
| id_byte | output | ID_W (8) | Received identifier, bit 0 received first |
| id_ok | output | 1 | Received identifier equals the expected value |

## Verification
The completion cycle and a new request can land on the same edge. The bench provokes this by holding `start` high through a whole read. It then judges that the `done` cycle ignores the request, that `isp_en_n` rises for exactly one cycle, and that a fresh read begins from idle with its own full lead time and strobe sequence. A second overlap is a `start` pulse and a `half_len` change that fall in the middle of the strobe train. There, every phase length and the strobe count are measured against the H latched at the original start.

// File: rtl/isp_id_pkg.sv
package isp_id_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LEAD,
      ST_HIGH,
      ST_LOW,
      ST_DONE
   } seq_state_t;

   // Control line codes applied before a strobe: {mode, sdi}
   localparam logic [1:0] CODE_TO_IDLE = 2'b10;
   localparam logic [1:0] CODE_EXEC    = 2'b00;
   localparam logic [1:0] CODE_DATA    = 2'b00;

   // Strobes preceding the data strobes
   localparam int PRE_STROBES = 2;

endpackage

// File: rtl/isp_phase_timer.sv
module isp_phase_timer #(
   parameter int CNT_W = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CNT_W-1:0] limit,
   output logic             tick
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) cnt <= '0;
      else               cnt <= cnt + 1'b1;
   end

   assign tick = (cnt == limit - 1'b1);
endmodule

// File: rtl/isp_bit_packer.sv
module isp_bit_packer #(
   parameter int ID_W      = 8,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            take,
   input  logic            bit_in,
   output logic [ID_W-1:0] word
);
   logic [ID_W-1:0] acc;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_ff @(posedge clk) begin
            if (!rst_n || clr) acc <= '0;
            else if (take)     acc <= {bit_in, acc[ID_W-1:1]};
         end
      end else begin : g_msb
         always_ff @(posedge clk) begin
            if (!rst_n || clr) acc <= '0;
            else if (take)     acc <= {acc[ID_W-2:0], bit_in};
         end
      end
   endgenerate

   assign word = acc;
endmodule

// File: rtl/isp_seq_ctrl.sv
module isp_seq_ctrl
   import isp_id_pkg::*;
#(
   parameter int HALF_W = 8,
   parameter int ID_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [HALF_W-1:0] half_len,
   output logic              en_n,
   output logic              sck,
   output logic              mode,
   output logic              sdi,
   output logic              sample,
   output logic              finish,
   output logic              clr_word,
   output seq_state_t        state
);
   localparam int NSTROBE = ID_W + PRE_STROBES;
   localparam int IDX_W   = $clog2(NSTROBE + 1);
   localparam int CNT_W   = HALF_W + 1;

   logic [IDX_W-1:0]  sidx;
   logic [HALF_W-1:0] hl;
   logic [CNT_W-1:0]  limit;
   logic              tick, clr_t, go;

   assign go       = (state == ST_IDLE) && start;
   assign limit    = (state == ST_LEAD) ? {hl, 1'b0} : {1'b0, hl};
   assign clr_t    = (state == ST_IDLE) || (state == ST_DONE) || tick;
   assign sample   = (state == ST_LOW) && tick && (sidx >= IDX_W'(PRE_STROBES - 1))
                     && (sidx != IDX_W'(NSTROBE - 1));
   assign finish   = (state == ST_LOW) && tick && (sidx == IDX_W'(NSTROBE - 1));
   assign clr_word = go;

   isp_phase_timer #(.CNT_W(CNT_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr_t),
      .limit (limit),
      .tick  (tick)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         en_n  <= 1'b1;
         sck   <= 1'b0;
         mode  <= 1'b0;
         sdi   <= 1'b0;
         sidx  <= '0;
         hl    <= HALF_W'(1);
      end else begin
         case (state)
            ST_IDLE: begin
               en_n <= 1'b1;
               sck  <= 1'b0;
               if (start) begin
                  state         <= ST_LEAD;
                  en_n          <= 1'b0;
                  {mode, sdi}   <= CODE_TO_IDLE;
                  sidx          <= '0;
                  hl            <= (half_len == '0) ? HALF_W'(1) : half_len;
               end
            end
            ST_LEAD: begin
               if (tick) begin
                  state <= ST_HIGH;
                  sck   <= 1'b1;
               end
            end
            ST_HIGH: begin
               if (tick) begin
                  state <= ST_LOW;
                  sck   <= 1'b0;
                  if (sidx == '0) {mode, sdi} <= CODE_EXEC;
                  else            {mode, sdi} <= CODE_DATA;
               end
            end
            ST_LOW: begin
               if (tick) begin
                  if (sidx == IDX_W'(NSTROBE - 1)) begin
                     state <= ST_DONE;
                  end else begin
                     state <= ST_HIGH;
                     sck   <= 1'b1;
                     sidx  <= sidx + 1'b1;
                  end
               end
            end
            ST_DONE: begin
               state <= ST_IDLE;
               en_n  <= 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/isp_id_reader.sv
module isp_id_reader
   import isp_id_pkg::*;
#(
   parameter int              HALF_W    = 8,
   parameter int              ID_W      = 8,
   parameter logic [ID_W-1:0] EXP_ID    = 8'h15,
   parameter bit              LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [HALF_W-1:0] half_len,
   input  logic              isp_sdo,
   output logic              isp_en_n,
   output logic              isp_sck,
   output logic              isp_mode,
   output logic              isp_sdi,
   output logic              busy,
   output logic              done,
   output logic [ID_W-1:0]   id_byte,
   output logic              id_ok
);
   generate
      if (HALF_W < 1 || HALF_W > 16) begin : g_bad_half
         $error("HALF_W must lie in 1..16");
      end
      if (ID_W < 2 || ID_W > 32) begin : g_bad_id
         $error("ID_W must lie in 2..32");
      end
   endgenerate

   seq_state_t      state;
   logic            sample, finish, clr_word;
   logic [ID_W-1:0] word;

   isp_seq_ctrl #(.HALF_W(HALF_W), .ID_W(ID_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .half_len (half_len),
      .en_n     (isp_en_n),
      .sck      (isp_sck),
      .mode     (isp_mode),
      .sdi      (isp_sdi),
      .sample   (sample),
      .finish   (finish),
      .clr_word (clr_word),
      .state    (state)
   );

   isp_bit_packer #(.ID_W(ID_W), .LSB_FIRST(LSB_FIRST)) u_pack (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr_word),
      .take   (sample),
      .bit_in (isp_sdo),
      .word   (word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         id_byte <= '0;
         id_ok   <= 1'b0;
      end else if (finish) begin
         id_byte <= word;
         id_ok   <= (word == EXP_ID);
      end
   end

   assign busy = (state != ST_IDLE);
   assign done = (state == ST_DONE);
endmodule

// File: rtl/isp_id_reader_chk.sv
module isp_id_reader_chk #(
   parameter int              ID_W   = 8,
   parameter logic [ID_W-1:0] EXP_ID = 8'h15
) (
   input logic            clk,
   input logic            rst_n,
   input logic            isp_en_n,
   input logic            isp_sck,
   input logic            isp_mode,
   input logic            isp_sdi,
   input logic            busy,
   input logic            done,
   input logic [ID_W-1:0] id_byte,
   input logic            id_ok
);
   localparam int NSTROBE = ID_W + 2;
   localparam int RC_W    = $clog2(NSTROBE + 2);

   logic [RC_W-1:0] rises;
   logic            sck_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rises <= '0;
         sck_q <= 1'b0;
      end else begin
         sck_q <= isp_sck;
         if (isp_en_n)            rises <= '0;
         else if (isp_sck && !sck_q) rises <= rises + 1'b1;
      end
   end

   a_r8_sck_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      isp_sck |-> !isp_en_n);

   a_r4_codes_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
      (isp_sck && $past(isp_sck)) |-> ($stable(isp_mode) && $stable(isp_sdi)));

   a_r4_ten_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rises == RC_W'(NSTROBE)));

   a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r7_ok_means_match: assert property (@(posedge clk) disable iff (!rst_n)
      (done && id_ok) |-> (id_byte == EXP_ID));

   a_r8_release_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> isp_en_n);

   a_r8_busy_with_enable: assert property (@(posedge clk) disable iff (!rst_n)
      !isp_en_n |-> busy);
endmodule

bind isp_id_reader isp_id_reader_chk #(.ID_W(ID_W), .EXP_ID(EXP_ID)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .isp_en_n (isp_en_n),
   .isp_sck  (isp_sck),
   .isp_mode (isp_mode),
   .isp_sdi  (isp_sdi),
   .busy     (busy),
   .done     (done),
   .id_byte  (id_byte),
   .id_ok    (id_ok)
);

// File: tb/isp_id_reader_bench.sv
module isp_id_reader_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] half_len = 8'd1;
   logic       isp_sdo;
   logic       isp_en_n, isp_sck, isp_mode, isp_sdi, busy, done, id_ok;
   logic [7:0] id_byte;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int exp_h = 1;

   always #(CLK_PERIOD / 2) clk = ~clk;

   isp_id_reader u_isp_id_reader (
      .clk (clk), .rst_n (rst_n), .start (start), .half_len (half_len),
      .isp_sdo (isp_sdo), .isp_en_n (isp_en_n), .isp_sck (isp_sck),
      .isp_mode (isp_mode), .isp_sdi (isp_sdi), .busy (busy), .done (done),
      .id_byte (id_byte), .id_ok (id_ok)
   );

   // Target model: idle on {1,0}, load on {0,x} from idle, shift on falls after data rises
   logic [7:0] tgt_id = 8'h00;
   logic [7:0] tshr = 8'h00;
   logic       tshift = 1'b0;
   logic       tadv = 1'b0;

   always @(posedge isp_sck) begin
      if (isp_mode && !isp_sdi) begin
         tshift <= 1'b0;
         tadv   <= 1'b0;
      end else if (!isp_mode) begin
         if (!tshift) begin
            tshr   <= tgt_id;
            tshift <= 1'b1;
            tadv   <= 1'b0;
         end else begin
            tadv <= 1'b1;
         end
      end
   end
   always @(negedge isp_sck) if (tadv) tshr <= tshr >> 1;
   assign isp_sdo = tshr[0];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic bit exp_ok(input logic [7:0] v);
      return v == 8'h15;
   endfunction

   // Protocol monitor, sampled mid-cycle
   logic en_prev = 1'b1, sck_prev = 1'b0, mode_prev = 1'b0, sdi_prev = 1'b0;
   int   t_en = 0, t_rise = 0, t_fall = 0, sidx = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (en_prev && !isp_en_n) begin
            t_en = cyc;
            sidx = 0;
            chk(isp_mode == 1'b1 && isp_sdi == 1'b0 && busy, "R2 lead code", {isp_mode, isp_sdi}, 2);
         end
         if (!sck_prev && isp_sck) begin
            if (sidx == 0) chk(cyc - t_en == 2 * exp_h, "R2 lead time", cyc - t_en, 2 * exp_h);
            else           chk(cyc - t_fall == exp_h, "R3 low phase", cyc - t_fall, exp_h);
            chk({isp_mode, isp_sdi} == ((sidx == 0) ? 2'b10 : 2'b00), "R4 strobe code",
                {isp_mode, isp_sdi}, (sidx == 0) ? 2 : 0);
            t_rise = cyc;
            sidx++;
         end
         if (sck_prev && !isp_sck) begin
            chk(cyc - t_rise == exp_h, "R3 high phase", cyc - t_rise, exp_h);
            t_fall = cyc;
         end
         if (sck_prev && isp_sck && (isp_mode != mode_prev || isp_sdi != sdi_prev))
            chk(1'b0, "R4 code moved while high", {isp_mode, isp_sdi}, {mode_prev, sdi_prev});
         if (isp_sck && isp_en_n) chk(1'b0, "R8 clock without enable", 1, 0);
         if (done) begin
            chk(sidx == 10, "R4 strobe count", sidx, 10);
            chk(cyc - t_fall == exp_h, "R6 done timing", cyc - t_fall, exp_h);
         end
      end
      en_prev = isp_en_n; sck_prev = isp_sck; mode_prev = isp_mode; sdi_prev = isp_sdi;
   end

   task automatic wait_done();
      int guard = 0;
      while (!done && guard < 20000) begin
         @(negedge clk);
         guard++;
      end
      chk(done, "R6 done seen", done, 1);
   endtask

   task automatic check_result(input logic [7:0] id);
      chk(id_byte == id, "R5 id_byte", id_byte, id);
      chk(id_ok == exp_ok(id), "R7 id_ok", id_ok, exp_ok(id));
      chk(busy, "R8 busy during done", busy, 1);
   endtask

   task automatic do_read(input logic [7:0] hl, input logic [7:0] id, input bit disturb);
      half_len = hl;
      tgt_id   = id;
      exp_h    = (hl == 0) ? 1 : int'(hl);
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      if (disturb) begin
         repeat (1 + $urandom_range(0, 19)) @(negedge clk);
         start    = 1'b1;                        // R9: ignored while busy
         half_len = 8'($urandom_range(0, 7));    // R10: no effect mid-read
         @(negedge clk); start = 1'b0;
      end
      wait_done();
      check_result(id);
      @(negedge clk);
      chk(!done, "R6 done one cycle", done, 0);
      chk(isp_en_n, "R8 enable released", isp_en_n, 1);
      chk(!busy, "R8 busy cleared", busy, 0);
      chk(id_byte == id, "R6 id_byte held", id_byte, id);
   endtask

   bit wd_hit = 1'b0;
   initial begin
      repeat (150000) @(posedge clk);
      wd_hit = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1d15));
      repeat (3) @(negedge clk);
      chk(isp_en_n && !isp_sck && !busy && !done && !id_ok && id_byte == 0,
          "R1 in reset", {isp_en_n, isp_sck, busy, done, id_ok}, 5'b10000);
      rst_n = 1'b1;
      @(negedge clk);
      chk(isp_en_n && !isp_sck && !busy && !done && !id_ok && id_byte == 0,
          "R1 after reset", {isp_en_n, isp_sck, busy, done, id_ok}, 5'b10000);

      // Directed corners
      do_read(8'd1, 8'h15, 1'b0);   // R7 match
      do_read(8'd0, 8'hA8, 1'b0);   // R10 zero half length, R5 order
      do_read(8'd3, 8'h80, 1'b0);   // R5 last bit lands in bit 7
      do_read(8'd2, 8'h01, 1'b1);   // R9 R10 disturbance mid-read

      // Random reads
      for (int i = 0; i < 12; i++) begin
         logic [7:0] id = (i % 4 == 0) ? 8'h15 : 8'($urandom);
         do_read(8'($urandom_range(0, 6)), id, ($urandom_range(0, 1) == 1));
      end

      // R9 R8: start held through done, new read must restart from idle
      half_len = 8'd2;
      exp_h    = 2;
      tgt_id   = 8'h6C;
      @(negedge clk); start = 1'b1;
      wait_done();
      check_result(8'h6C);
      @(negedge clk);
      chk(isp_en_n && !busy, "R9 done ignores start", isp_en_n, 1);
      @(negedge clk);
      chk(!isp_en_n && busy, "R8 restart from idle", isp_en_n, 0);
      start  = 1'b0;
      tgt_id = 8'h15;
      wait_done();
      check_result(8'h15);
      @(negedge clk);

      if (!wd_hit) begin
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule